// File: doc/BRIEF.md
# Stalling Pipeline Stage Latch

This block is the register that sits at the boundary of one stage of an in-order pipeline. It takes an item (a valid flag plus a data word) from the stage before it. It shows the item it is working on to the stage's own logic, which answers with a one-bit "can proceed". It then passes the item to the next stage or holds it back. A one-bit stall arrives from the next stage, and the block sends a one-bit stall to the previous stage. Both the forward link and the backward link are registered, so each one adds exactly one cycle. A stall therefore moves back one stage per cycle.

A small state machine controls the block. It has three states:
- `ST_IDLE`: nothing is held that needs work.
- `ST_PEND`: a held item could not proceed and must be retried.
- `ST_KEEP`: the last forwarded item is kept so that it can be worked on again.

The transitions are:
- Item accepted and proceeds: to `ST_IDLE`, or to `ST_KEEP` in re-evaluate mode.
- Item cannot proceed: to `ST_PEND`.
- Pending item finally proceeds: leaves `ST_PEND`.
- Downstream stall: the state holds.

A parameter selects the mode. In bubble mode, a cycle with no arrival produces nothing. In re-evaluate mode, the stage works again on the word it already holds, which suits a decode stage. Two more parameters turn the block into a first stage, which has no upstream stall, or a last stage, which has no downstream link.

Top module: `pipe_stage_latch`

## Requirements
- R1: An item on `work_data_o` with `work_valid_o` high and `can_go_i` high in cycle t appears on `dn_valid_o`/`dn_data_o` in cycle t+1. Back-to-back arrivals forward on consecutive cycles.
- R2: When `dn_stall_i` is high in cycle t (downstream link present), `work_valid_o` is low in cycle t. In cycle t+1, `dn_valid_o` is low and `up_stall_o` is high. The state and the held word are unchanged, and an arrival in cycle t is ignored.
- R3: When an item is presented with `can_go_i` low, `dn_valid_o` is low and `up_stall_o` is high the next cycle. The item is held (`ST_PEND`) and presented again on `work_data_o` every later cycle until it proceeds. New arrivals are ignored while it is pending.
- R4: In bubble mode (`REEVAL`=0), a cycle with no arrival and nothing pending gives `work_valid_o` low, and `dn_valid_o` and `up_stall_o` low the next cycle.
- R5: In re-evaluate mode (`REEVAL`=1), a cycle with no arrival after an item has been forwarded presents that same word again on `work_data_o` and forwards it again if `can_go_i` is high.
- R6: In re-evaluate mode, before any item has been accepted since reset, a cycle with no arrival presents nothing.
- R7: `dn_valid_o` and `up_stall_o` are never high in the same cycle.
- R8: With `HAS_UP`=0 (first stage), `up_stall_o` stays low even when an item cannot proceed.
- R9: With `HAS_DOWN`=0 (last stage), `dn_stall_i` has no effect on `work_valid_o`, and `dn_valid_o` stays low.
- R10: A synchronous active-high `rst` returns the state to `ST_IDLE` and drives `dn_valid_o` and `up_stall_o` low. A pending item is dropped, and the next arrival is presented instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid_i | input | 1 | Item arriving from the previous stage |
| up_data_i | input | DATA_W | Data of the arriving item |
| up_stall_o | output | 1 | Registered stall toward the previous stage |
| can_go_i | input | 1 | Stage logic accepts the presented item this cycle |
| work_valid_o | output | 1 | An item is presented to the stage logic |
| work_data_o | output | DATA_W | Data of the presented item |
| dn_stall_i | input | 1 | Stall from the next stage |
| dn_valid_o | output | 1 | Registered item valid toward the next stage |
| dn_data_o | output | DATA_W | Registered item data toward the next stage |

## Verification
The bench builds three instances with an 8-bit data word, all driven from the same inputs:
- The bubble-mode middle stage runs a vector table that covers forwarding, downstream stall, retry of a pending item and bubbles.
- The re-evaluate instance shows a word presented again after it has been forwarded, and the empty case right after reset.
- A third instance, with both the upstream and downstream links removed, shows that no stall is sent back and that a downstream stall has no effect.

// File: rtl/psl_pkg.sv
package psl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_KEEP = 2'd2
    } psl_state_e;

    typedef enum logic {
        SRC_UP   = 1'b0,
        SRC_HELD = 1'b1
    } psl_src_e;

endpackage

// File: rtl/psl_fsm.sv
module psl_fsm
    import psl_pkg::*;
#(
    parameter bit REEVAL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     up_valid,
    input  logic     dn_stall,
    input  logic     can_go,
    output logic     cand_valid,
    output psl_src_e cand_src,
    output logic     load_hold,
    output logic     fwd,
    output logic     stall_req
);

    psl_state_e state_q;
    psl_state_e state_nxt;
    logic       have_cand;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        have_cand  = 1'b0;
        cand_src   = SRC_UP;
        cand_valid = 1'b0;
        load_hold  = 1'b0;
        fwd        = 1'b0;
        stall_req  = 1'b0;
        state_nxt  = state_q;

        unique case (state_q)
            ST_IDLE: begin
                have_cand = up_valid;
                cand_src  = SRC_UP;
            end
            ST_KEEP: begin
                have_cand = 1'b1;
                cand_src  = up_valid ? SRC_UP : SRC_HELD;
            end
            ST_PEND: begin
                have_cand = 1'b1;
                cand_src  = SRC_HELD;
            end
            default: begin
                have_cand = 1'b0;
                cand_src  = SRC_UP;
            end
        endcase

        if (dn_stall) begin
            stall_req = 1'b1;
        end else if (have_cand) begin
            cand_valid = 1'b1;
            load_hold  = (cand_src == SRC_UP);
            if (can_go) begin
                fwd       = 1'b1;
                state_nxt = REEVAL ? ST_KEEP : ST_IDLE;
            end else begin
                stall_req = 1'b1;
                state_nxt = ST_PEND;
            end
        end
    end

endmodule

// File: rtl/psl_hold.sv
module psl_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (load) begin
            word_q <= d;
        end
    end

    assign q = word_q;

endmodule

// File: rtl/psl_outreg.sv
module psl_outreg #(
    parameter int W        = 32,
    parameter bit HAS_UP   = 1'b1,
    parameter bit HAS_DOWN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fwd,
    input  logic         stall_req,
    input  logic [W-1:0] cand_data,
    output logic         dn_valid,
    output logic [W-1:0] dn_data,
    output logic         up_stall
);

    generate
        if (HAS_DOWN) begin : g_down
            logic         v_q;
            logic [W-1:0] d_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                end else begin
                    v_q <= fwd;
                end
                if (fwd) begin
                    d_q <= cand_data;
                end
            end
            assign dn_valid = v_q;
            assign dn_data  = d_q;
        end else begin : g_no_down
            assign dn_valid = 1'b0;
            assign dn_data  = '0;
        end

        if (HAS_UP) begin : g_up
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s_q <= 1'b0;
                end else begin
                    s_q <= stall_req;
                end
            end
            assign up_stall = s_q;
        end else begin : g_no_up
            assign up_stall = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pipe_stage_latch.sv
module pipe_stage_latch
    import psl_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit REEVAL   = 1'b0,
    parameter bit HAS_UP   = 1'b1,
    parameter bit HAS_DOWN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid_i,
    input  logic [DATA_W-1:0] up_data_i,
    output logic              up_stall_o,
    input  logic              can_go_i,
    output logic              work_valid_o,
    output logic [DATA_W-1:0] work_data_o,
    input  logic              dn_stall_i,
    output logic              dn_valid_o,
    output logic [DATA_W-1:0] dn_data_o
);

    logic              dn_stall_eff;
    logic              cand_valid;
    psl_src_e          cand_src;
    logic              load_hold;
    logic              fwd;
    logic              stall_req;
    logic [DATA_W-1:0] held_word;
    logic [DATA_W-1:0] cand_data;

    generate
        if (HAS_DOWN) begin : g_stall_in
            assign dn_stall_eff = dn_stall_i;
        end else begin : g_stall_none
            assign dn_stall_eff = 1'b0;
        end
    endgenerate

    psl_fsm #(
        .REEVAL (REEVAL)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .up_valid   (up_valid_i),
        .dn_stall   (dn_stall_eff),
        .can_go     (can_go_i),
        .cand_valid (cand_valid),
        .cand_src   (cand_src),
        .load_hold  (load_hold),
        .fwd        (fwd),
        .stall_req  (stall_req)
    );

    psl_hold #(
        .W (DATA_W)
    ) hold_i (
        .clk  (clk),
        .load (load_hold),
        .d    (up_data_i),
        .q    (held_word)
    );

    assign cand_data = (cand_src == SRC_HELD) ? held_word : up_data_i;

    psl_outreg #(
        .W        (DATA_W),
        .HAS_UP   (HAS_UP),
        .HAS_DOWN (HAS_DOWN)
    ) out_i (
        .clk       (clk),
        .rst       (rst),
        .fwd       (fwd),
        .stall_req (stall_req),
        .cand_data (cand_data),
        .dn_valid  (dn_valid_o),
        .dn_data   (dn_data_o),
        .up_stall  (up_stall_o)
    );

    assign work_valid_o = cand_valid;
    assign work_data_o  = cand_data;

endmodule

// File: rtl/psl_checker.sv
module psl_checker #(
    parameter int DATA_W   = 32,
    parameter bit HAS_UP   = 1'b1,
    parameter bit HAS_DOWN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              dn_stall_i,
    input logic              can_go_i,
    input logic              work_valid_o,
    input logic [DATA_W-1:0] work_data_o,
    input logic              dn_valid_o,
    input logic [DATA_W-1:0] dn_data_o,
    input logic              up_stall_o
);

    logic dstall;
    assign dstall = HAS_DOWN && dn_stall_i;

    assert_fwd_R1: assert property (@(posedge clk) disable iff (rst)
        (HAS_DOWN && work_valid_o && can_go_i) |=>
            (dn_valid_o && dn_data_o == $past(work_data_o)));

    assert_dnstall_R2: assert property (@(posedge clk) disable iff (rst)
        dstall |=> (!dn_valid_o && (up_stall_o || !HAS_UP)));

    assert_nogo_R3: assert property (@(posedge clk) disable iff (rst)
        (work_valid_o && !can_go_i) |=>
            (!dn_valid_o && (up_stall_o || !HAS_UP) &&
             (dstall || (work_valid_o && $stable(work_data_o)))));

    assert_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!work_valid_o && !dstall) |=> (!dn_valid_o && !up_stall_o));

    assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(dn_valid_o && up_stall_o));

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (!dn_valid_o && !up_stall_o));

endmodule

bind pipe_stage_latch psl_checker #(
    .DATA_W   (DATA_W),
    .HAS_UP   (HAS_UP),
    .HAS_DOWN (HAS_DOWN)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .dn_stall_i   (dn_stall_i),
    .can_go_i     (can_go_i),
    .work_valid_o (work_valid_o),
    .work_data_o  (work_data_o),
    .dn_valid_o   (dn_valid_o),
    .dn_data_o    (dn_data_o),
    .up_stall_o   (up_stall_o)
);

// File: tb/pipe_stage_latch_tb_top.sv
module pipe_stage_latch_tb_top;

    localparam int W  = 8;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         up_valid = 1'b0;
    logic [W-1:0] up_data = '0;
    logic         dn_stall = 1'b0;
    logic         can_go = 1'b0;

    logic         m_us, m_wv, m_dv;
    logic [W-1:0] m_wd, m_dd;
    logic         r_us, r_wv, r_dv;
    logic [W-1:0] r_wd, r_dd;
    logic         e_us, e_wv, e_dv;
    logic [W-1:0] e_wd, e_dd;

    int applied = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pipe_stage_latch #(.DATA_W(W), .REEVAL(1'b0)) dut_i (
        .clk(clk), .rst(rst), .up_valid_i(up_valid), .up_data_i(up_data),
        .up_stall_o(m_us), .can_go_i(can_go), .work_valid_o(m_wv),
        .work_data_o(m_wd), .dn_stall_i(dn_stall), .dn_valid_o(m_dv),
        .dn_data_o(m_dd));

    pipe_stage_latch #(.DATA_W(W), .REEVAL(1'b1)) dut_re_i (
        .clk(clk), .rst(rst), .up_valid_i(up_valid), .up_data_i(up_data),
        .up_stall_o(r_us), .can_go_i(can_go), .work_valid_o(r_wv),
        .work_data_o(r_wd), .dn_stall_i(dn_stall), .dn_valid_o(r_dv),
        .dn_data_o(r_dd));

    pipe_stage_latch #(.DATA_W(W), .REEVAL(1'b0), .HAS_UP(1'b0), .HAS_DOWN(1'b0)) dut_edge_i (
        .clk(clk), .rst(rst), .up_valid_i(up_valid), .up_data_i(up_data),
        .up_stall_o(e_us), .can_go_i(can_go), .work_valid_o(e_wv),
        .work_data_o(e_wd), .dn_stall_i(dn_stall), .dn_valid_o(e_dv),
        .dn_data_o(e_dd));

    // fields: upv[29] ud[28:21] st[20] go[19] wv[18] wd[17:10] dv[9] dd[8:1] us[0]
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 8'hA1, 1'b0, 1'b1, 1'b1, 8'hA1, 1'b1, 8'hA1, 1'b0}, // R1 forward
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 bubble
        {1'b1, 8'hB2, 1'b0, 1'b0, 1'b1, 8'hB2, 1'b0, 8'h00, 1'b1}, // R3 cannot go
        {1'b1, 8'hC3, 1'b0, 1'b1, 1'b1, 8'hB2, 1'b1, 8'hB2, 1'b0}, // R3 retry, C3 ignored
        {1'b1, 8'hD4, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // R2 downstream stall
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 D4 was ignored
        {1'b1, 8'hE5, 1'b0, 1'b0, 1'b1, 8'hE5, 1'b0, 8'h00, 1'b1}, // R3 pending
        {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1}, // R2 stall over pending
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hE5, 1'b1, 8'hE5, 1'b0}, // R3 pending proceeds
        {1'b1, 8'hF6, 1'b0, 1'b1, 1'b1, 8'hF6, 1'b1, 8'hF6, 1'b0}, // R1 back to back
        {1'b1, 8'h17, 1'b0, 1'b1, 1'b1, 8'h17, 1'b1, 8'h17, 1'b0}, // R1 back to back
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}  // R4 bubble
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [W-1:0] d, input logic s, input logic g);
        @(negedge clk);
        up_valid = v;
        up_data  = d;
        dn_stall = s;
        can_go   = g;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        up_valid = 1'b0;
        dn_stall = 1'b0;
        can_go = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        chk("R10 reset dn_valid", {31'b0, m_dv}, 32'd0);
        chk("R10 reset up_stall", {31'b0, m_us}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][29], VEC[i][28:21], VEC[i][20], VEC[i][19]);
            chk($sformatf("vec%0d work_valid", i), {31'b0, m_wv}, {31'b0, VEC[i][18]});
            if (VEC[i][18]) chk($sformatf("vec%0d work_data", i), {24'b0, m_wd}, {24'b0, VEC[i][17:10]});
            tick();
            chk($sformatf("vec%0d dn_valid", i), {31'b0, m_dv}, {31'b0, VEC[i][9]});
            if (VEC[i][9]) chk($sformatf("vec%0d dn_data", i), {24'b0, m_dd}, {24'b0, VEC[i][8:1]});
            chk($sformatf("vec%0d up_stall", i), {31'b0, m_us}, {31'b0, VEC[i][0]});
            chk($sformatf("vec%0d R7 exclusive", i), {31'b0, m_dv & m_us}, 32'd0);
        end

        // R10: reset while an item is pending drops it
        drive(1'b1, 8'h42, 1'b0, 1'b0);
        tick();
        do_reset();
        chk("R10 up_stall after reset", {31'b0, m_us}, 32'd0);
        chk("R10 dn_valid after reset", {31'b0, m_dv}, 32'd0);
        drive(1'b1, 8'h99, 1'b0, 1'b1);
        chk("R10 new item presented", {24'b0, m_wd}, 32'h99);
        tick();

        // R6 / R5: re-evaluate mode
        do_reset();
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 empty after reset", {31'b0, r_wv}, 32'd0);
        tick();
        chk("R6 no output", {31'b0, r_dv}, 32'd0);
        drive(1'b1, 8'h3A, 1'b0, 1'b1);
        tick();
        chk("R1 reeval forward", {24'b0, r_dd}, 32'h3A);
        drive(1'b0, 8'h00, 1'b0, 1'b1);
        chk("R5 re-presented valid", {31'b0, r_wv}, 32'd1);
        chk("R5 re-presented data", {24'b0, r_wd}, 32'h3A);
        chk("R4 bubble mode no work", {31'b0, m_wv}, 32'd0);
        tick();
        chk("R5 forwarded again", {31'b0, r_dv}, 32'd1);
        chk("R5 forwarded data", {24'b0, r_dd}, 32'h3A);
        chk("R4 bubble mode no output", {31'b0, m_dv}, 32'd0);
        drive(1'b0, 8'h00, 1'b0, 1'b0);
        tick();
        chk("R3 reeval stall", {31'b0, r_us}, 32'd1);
        drive(1'b1, 8'h5C, 1'b0, 1'b1);
        chk("R3 reeval pending presented", {24'b0, r_wd}, 32'h3A);
        tick();
        chk("R3 reeval pending forwarded", {24'b0, r_dd}, 32'h3A);
        drive(1'b1, 8'h5C, 1'b0, 1'b1);
        tick();
        chk("R1 reeval new item", {24'b0, r_dd}, 32'h5C);

        // R8 / R9: first and last stage variant
        do_reset();
        drive(1'b1, 8'h55, 1'b1, 1'b0);
        chk("R9 downstream stall ignored", {31'b0, e_wv}, 32'd1);
        tick();
        chk("R8 no upstream stall", {31'b0, e_us}, 32'd0);
        chk("R9 no downstream output", {31'b0, e_dv}, 32'd0);
        drive(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R9 pending still presented", {24'b0, e_wd}, 32'h55);
        tick();
        chk("R9 dn_valid stays low", {31'b0, e_dv}, 32'd0);

        finish_run();
    end

endmodule